// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events from six sources and presents them to a processor core as two request lines, one high and one low, with a vector index. The sources are four external edge-triggered pins, a timer wrap strobe, and one shared change detector that watches four port pins. Each source owns a sticky flag, an enable bit and a priority bit. All of them sit in a small register bank that is reached through a synchronous read/write bus. Every pin input is resynchronised by two flops before any edge or change is detected.

A wake-up output tells a sleeping core that some enabled source is pending, whatever the global enable is. A separate branch output asks the core to jump to the interrupt vector. The branch output also needs the global enable bit. Among the sources of one level, the vector index follows a fixed order. External source 0 always sits at the high level.

Register map: bus address 0 holds the flags, address 1 the enables plus the global enable, address 2 the priorities, address 3 the per-pin edge polarity, and address 4 the port pin snapshot. Within the flag, enable and priority registers, bits 0 to 3 are external sources 0 to 3, bit 4 is the timer and bit 5 is the port change.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, the bus reads these values: flags 0, enables 0, global enable 0, priority 0x01, polarity 0x0F. The outputs irq_hi, irq_lo, wake_req and branch_req are all 0.
- R2: Each external pin has a polarity bit at address 3, bits 3:0. A value of 1 selects the rising edge and 0 selects the falling edge. A valid edge sets the pin's flag on the third rising clock edge after the pin changes, and not before.
- R3: A flag stays set until software writes a 1 to its bit at address 0. Writing 0 to a flag bit leaves that bit unchanged.
- R4: If a clearing write and a new set event fall on the same clock edge, the flag stays set.
- R5: A flag produces a request, a wake-up or a branch only while its enable bit at address 1, bits 5:0, is 1.
- R6: A priority bit of 1 at address 2 puts its source at the high level. Bit 0 always reads 1 and ignores writes, so external source 0 is always high.
- R7: irq_lo is 0 whenever irq_hi is 1. irq_vec gives the lowest-numbered pending enabled source of the winning level: 0 to 3 for the external pins, 4 for the timer, 5 for the port change.
- R8: A one-cycle pulse on tmr_ovf sets the timer flag (bit 4) on the same clock edge.
- R9: The port-change flag (bit 5) is set on every clock edge on which the synchronised port pins differ from a stored copy. The copy is loaded when address 4 is read. Until that read, a mismatch that persists sets the flag again right after a clear. Reading address 4 returns the synchronised port value.
- R10: wake_req is 1 whenever any enabled flag is set, whatever the global enable is. branch_req additionally needs the global enable at address 1, bit 6.
- R11: The enable, priority and polarity registers read back the values written to them, with priority bit 0 forced as R6 states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | External interrupt pins, asynchronous |
| port_pin | input | 4 | Watched port pins, asynchronous |
| tmr_ovf | input | 1 | Timer wrap strobe, synchronous to clk |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; loads the port copy when the address is 4 |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data, combinational from the address |
| irq_hi | output | 1 | High-level interrupt request |
| irq_lo | output | 1 | Low-level interrupt request |
| irq_vec | output | 3 | Index of the winning source |
| wake_req | output | 1 | Wake-up request to a sleeping core |
| branch_req | output | 1 | Branch-to-vector request |

## Verification
A pin edge reaches its flag on the third rising clock edge after the change. A timer strobe or a register write takes effect on the first edge. The request outputs and the read data follow combinationally from registered state, so they are valid in the same cycle as the flag or register they depend on. The bench drives every input on a falling edge, counts the stated number of rising edges, and samples on the next falling edge. It also samples one edge early, where a flag must still be clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NEXT   = 4;
    localparam int NPCH   = 4;
    localparam int NSRC   = NEXT + 2;
    localparam int DW     = NSRC + 1;
    localparam int AW     = 3;
    localparam int VW     = $clog2(NSRC);
    localparam int SRC_TMR  = NEXT;
    localparam int SRC_PORT = NEXT + 1;

    typedef enum logic [AW-1:0] {
        REG_FLAG = 3'd0,
        REG_ENA  = 3'd1,
        REG_PRIO = 3'd2,
        REG_POL  = 3'd3,
        REG_PORT = 3'd4
    } reg_addr_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic [VW-1:0] vec;
    } irq_req_t;

    function automatic logic [VW-1:0] first_set(src_vec_t v);
        logic [VW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = VW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NEXT-1:0]  ext_s,
    input  logic [NEXT-1:0]  pol,
    input  logic [NPCH-1:0]  port_s,
    input  logic             tmr_ovf,
    input  src_vec_t         clr,
    input  logic             port_rd,
    output src_vec_t         flag_q
);
    logic [NEXT-1:0] ext_prev;
    logic [NEXT-1:0] edge_hit;
    logic [NPCH-1:0] port_lat;
    logic            port_diff;
    src_vec_t        set_ev;

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= '0;
        else     ext_prev <= ext_s;
    end

    genvar i;
    generate
        for (i = 0; i < NEXT; i++) begin : g_edge
            assign edge_hit[i] = pol[i] ? (ext_s[i] & ~ext_prev[i])
                                        : (~ext_s[i] & ext_prev[i]);
        end
    endgenerate

    assign port_diff = |(port_s ^ port_lat);
    assign set_ev    = {port_diff, tmr_ovf, edge_hit};

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q   <= '0;
            port_lat <= '0;
        end else begin
            flag_q <= (flag_q & ~clr) | set_ev;
            if (port_rd) port_lat <= port_s;
        end
    end

    generate
        for (i = 0; i < NSRC; i++) begin : g_chk
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                set_ev[i] |=> flag_q[i]); // R4
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && !clr[i]) |=> flag_q[i]); // R3
            AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && clr[i] && !set_ev[i]) |=> !flag_q[i]); // R3
        end
    endgenerate
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
(
    input  src_vec_t flag,
    input  src_vec_t en,
    input  src_vec_t prio,
    input  logic     gie,
    output irq_req_t req,
    output logic     wake,
    output logic     branch
);
    src_vec_t pend, hi_v, lo_v;

    always_comb begin
        pend       = flag & en;
        hi_v       = pend & prio;
        lo_v       = pend & ~prio;
        req.hi     = |hi_v;
        req.lo     = (|lo_v) & ~req.hi;
        req.vec    = req.hi ? first_set(hi_v) : first_set(lo_v);
        wake       = |pend;
        branch     = wake & gie;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    ext_pin,
    input  logic [3:0]    port_pin,
    input  logic          tmr_ovf,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [6:0]    bus_wdata,
    output logic [6:0]    bus_rdata,
    output logic          irq_hi,
    output logic          irq_lo,
    output logic [2:0]    irq_vec,
    output logic          wake_req,
    output logic          branch_req
);
    localparam int SYNC_STAGES = 2;

    reg_addr_e        addr;
    logic [NEXT-1:0]  ext_s;
    logic [NPCH-1:0]  port_s;
    src_vec_t         flag_q, en_q, prio_eff, clr;
    logic [NSRC-1:1]  prio_q;
    logic [NEXT-1:0]  pol_q;
    logic             gie_q;
    logic             port_rd;
    irq_req_t         req;

    assign addr = reg_addr_e'(bus_addr);

    irq_sync #(.W(NEXT), .STAGES(SYNC_STAGES)) i_sync_ext (
        .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s)
    );

    irq_sync #(.W(NPCH), .STAGES(SYNC_STAGES)) i_sync_port (
        .clk(clk), .rst(rst), .d(port_pin), .q(port_s)
    );

    assign clr     = (bus_wr && addr == REG_FLAG) ? bus_wdata[NSRC-1:0] : '0;
    assign port_rd = bus_rd && addr == REG_PORT;

    irq_flags i_flags (
        .clk(clk), .rst(rst), .ext_s(ext_s), .pol(pol_q), .port_s(port_s),
        .tmr_ovf(tmr_ovf), .clr(clr), .port_rd(port_rd), .flag_q(flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            gie_q  <= 1'b0;
            prio_q <= '0;
            pol_q  <= '1;
        end else if (bus_wr) begin
            case (addr)
                REG_ENA: begin
                    en_q  <= bus_wdata[NSRC-1:0];
                    gie_q <= bus_wdata[NSRC];
                end
                REG_PRIO: prio_q <= bus_wdata[NSRC-1:1];
                REG_POL:  pol_q  <= bus_wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end

    assign prio_eff = {prio_q, 1'b1};

    always_comb begin
        case (addr)
            REG_FLAG: bus_rdata = {1'b0, flag_q};
            REG_ENA:  bus_rdata = {gie_q, en_q};
            REG_PRIO: bus_rdata = {1'b0, prio_eff};
            REG_POL:  bus_rdata = {{(DW-NEXT){1'b0}}, pol_q};
            REG_PORT: bus_rdata = {{(DW-NPCH){1'b0}}, port_s};
            default:  bus_rdata = '0;
        endcase
    end

    irq_arb i_arb (
        .flag(flag_q), .en(en_q), .prio(prio_eff), .gie(gie_q),
        .req(req), .wake(wake_req), .branch(branch_req)
    );

    assign irq_hi  = req.hi;
    assign irq_lo  = req.lo;
    assign irq_vec = req.vec;

    AST_SRC0_HIGH: assert property (@(posedge clk) disable iff (rst)
        (flag_q[0] && en_q[0]) |-> (irq_hi && irq_vec == 3'd0)); // R6
    AST_LEVELS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(irq_hi && irq_lo)); // R7
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (irq_hi || irq_lo) |-> (int'(irq_vec) < NSRC)); // R7
    AST_BRANCH_GATED: assert property (@(posedge clk) disable iff (rst)
        branch_req |-> (wake_req && gie_q)); // R10
    AST_WAKE_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (irq_hi || irq_lo)); // R5
    AST_TMR_FLAG: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> flag_q[SRC_TMR]); // R8
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ext_pin, port_pin;
    logic       tmr_ovf;
    logic [2:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [6:0] bus_wdata, bus_rdata;
    logic       irq_hi, irq_lo, wake_req, branch_req;
    logic [2:0] irq_vec;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_pin(port_pin),
        .tmr_ovf(tmr_ovf), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_hi(irq_hi),
        .irq_lo(irq_lo), .irq_vec(irq_vec), .wake_req(wake_req),
        .branch_req(branch_req)
    );

    // {enable[6:0], priority[6:0], hi, lo, vec[2:0], wake, branch}, all six flags set
    localparam int NTBL = 11;
    localparam logic [20:0] TBL [NTBL] = '{
        {7'h00, 7'h00, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
        {7'h01, 7'h00, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0},
        {7'h02, 7'h00, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0},
        {7'h06, 7'h04, 1'b1, 1'b0, 3'd2, 1'b1, 1'b0},
        {7'h30, 7'h00, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0},
        {7'h20, 7'h20, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0},
        {7'h3E, 7'h30, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0},
        {7'h7F, 7'h00, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1},
        {7'h48, 7'h08, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1},
        {7'h58, 7'h08, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1},
        {7'h70, 7'h00, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [6:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [6:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek_flags(output logic [6:0] d);
        bus_addr = 3'd0;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] v;
        rst = 1'b1; ext_pin = '0; port_pin = '0; tmr_ovf = 1'b0;
        bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 outputs", {irq_hi, irq_lo, wake_req, branch_req}, 4'b0000);
        rd(3'd0, v); chk("R1 flags", v, 7'h00);
        rd(3'd1, v); chk("R1 enable", v, 7'h00);
        rd(3'd2, v); chk("R1 priority", v, 7'h01);
        rd(3'd3, v); chk("R1 polarity", v, 7'h0F);

        // R11 readback
        wr(3'd1, 7'h3F); rd(3'd1, v); chk("R11 enable", v, 7'h3F);

        // R2 rising edge, three-edge latency
        ext_pin[1] = 1'b1;
        edges(2); peek_flags(v); chk("R2 not yet", v, 7'h00);
        edges(1); peek_flags(v); chk("R2 rising", v, 7'h02);
        chk("R7 low vec1", {irq_hi, irq_lo, irq_vec}, {1'b0, 1'b1, 3'd1});
        wr(3'd0, 7'h02); peek_flags(v); chk("R3 clear", v, 7'h00);

        // R2 falling polarity, R3 zero-write
        wr(3'd3, 7'h0D); rd(3'd3, v); chk("R11 polarity", v, 7'h0D);
        ext_pin[1] = 1'b0;
        edges(3); peek_flags(v); chk("R2 falling", v, 7'h02);
        wr(3'd0, 7'h3D); peek_flags(v); chk("R3 zero write", v, 7'h02);
        wr(3'd0, 7'h02);

        // R4 same-edge clear and set
        wr(3'd3, 7'h0F);
        ext_pin[1] = 1'b1;
        edges(2);
        bus_addr = 3'd0; bus_wdata = 7'h02; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        peek_flags(v); chk("R4 set wins", v, 7'h02);
        wr(3'd0, 7'h02); peek_flags(v); chk("R4 single edge", v, 7'h00);

        // R8 timer strobe, R10 wake without branch
        tmr_ovf = 1'b1; @(posedge clk); @(negedge clk); tmr_ovf = 1'b0;
        peek_flags(v); chk("R8 timer flag", v, 7'h10);
        chk("R10 wake no branch", {irq_lo, irq_vec, wake_req, branch_req},
            {1'b1, 3'd4, 1'b1, 1'b0});
        wr(3'd0, 7'h10);

        // R9 port change
        port_pin = 4'h5;
        edges(3); peek_flags(v); chk("R9 port flag", v, 7'h20);
        wr(3'd0, 7'h20); peek_flags(v); chk("R9 re-set", v, 7'h20);
        rd(3'd4, v); chk("R9 port value", v, 7'h05);
        wr(3'd0, 7'h20); edges(2); peek_flags(v); chk("R9 cleared", v, 7'h00);

        // R6 fixed priority bit
        wr(3'd2, 7'h00); rd(3'd2, v); chk("R6 bit0 fixed", v, 7'h01);
        wr(3'd2, 7'h2A); rd(3'd2, v); chk("R11 priority", v, 7'h2B);
        wr(3'd1, 7'h00);

        // set all six flags
        ext_pin = 4'h0; edges(3);
        ext_pin = 4'hF; edges(3);
        tmr_ovf = 1'b1; @(posedge clk); @(negedge clk); tmr_ovf = 1'b0;
        port_pin = 4'hA; edges(3);
        peek_flags(v); chk("R2 all flags", v, 7'h3F);

        // R5 R6 R7 R10 table
        for (int k = 0; k < NTBL; k++) begin
            wr(3'd1, TBL[k][20:14]);
            wr(3'd2, TBL[k][13:7]);
            chk($sformatf("R7 R5 entry %0d", k), {irq_hi, irq_lo, irq_vec},
                TBL[k][6:2]);
            chk($sformatf("R10 entry %0d", k), {wake_req, branch_req}, TBL[k][1:0]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule